// File: doc/BRIEF.md
# SPI Controller Status and Mode Flags

This block holds the status state of a serial peripheral controller. It keeps six sticky error flags: mode fault, transmit overflow, receive overflow, abort, transmit underflow and receive underflow. It also keeps two control bits: host/target select and the operational-enable bit. Clearing the enable bit puts the controller in configuration mode, and setting it puts the controller in operational mode.

Software cannot write these bits directly. It changes them only by strobing a 16-bit command word. For every bit, the command word has one position that sets it and another position that clears it. Event inputs from the rest of the controller also set the error flags. Five of these events are gated by per-error enables. The mode-fault event is not gated. One interrupt output is high while any error flag is set. The status word is read back in a fixed layout, and it also carries the shifter's busy bit.

Top module: `ssc_status_ctl`

## Requirements
- R1: After reset, every flag, the host-select bit and the enable bit read 0, and `err_irq` is low.
- R2: On a write with `cmd_we`=1, a 1 in the set position of a bit makes that bit 1 from the next cycle on. The set positions are: 15 transmit underflow, 14 abort, 13 receive overflow, 12 transmit overflow, 7 mode fault, 5 receive underflow, 3 host select, 1 enable.
- R3: On a write, a 1 in the clear position of a bit makes that bit 0 from the next cycle on. The clear positions are: 11 transmit underflow, 10 abort, 9 receive overflow, 8 transmit overflow, 6 mode fault, 4 receive underflow, 2 host select, 0 enable.
- R4: If a write has both the set and the clear position of the same bit at 1, that bit keeps its value.
- R5: An event on `err_evt` sets its flag on the next cycle when the matching `err_en` bit is 1. The event bit order is: 0 transmit overflow, 1 receive overflow, 2 abort, 3 transmit underflow, 4 receive underflow, 5 mode fault. `err_en` bits 0 to 4 gate event bits 0 to 4. Event bit 5 always sets its flag.
- R6: An event whose `err_en` bit is 0 leaves its flag unchanged.
- R7: An event in the same cycle as a software clear of the same flag leaves the flag set.
- R8: `status` places its bits as follows: 13 busy (passed straight from `busy_i`), 12 receive underflow, 11 transmit underflow, 10 abort, 9 receive overflow, 8 transmit overflow, 7 mode fault, 1 host select, 0 enable. All other bits read 0.
- R9: `err_irq` is high exactly when at least one of the six error flags is set. A single write of 0x0F50 clears all six flags and drops the interrupt on the next cycle.
- R10: When `cmd_we` is 0, the value on `cmd_word` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_word | input | 16 | Set/clear command word |
| err_en | input | 5 | Per-error event enables |
| err_evt | input | 6 | Hardware error events |
| busy_i | input | 1 | Shifter busy, mirrored into status |
| status | output | 16 | Status readback |
| err_irq | output | 1 | Combined error interrupt |

## Verification
The hardest case to reach is a collision: a hardware event and a software write that touch the same flag in the same clock. This includes a write that both sets and clears a bit while an event also fires. Directed steps place a transmit-overflow event in the same cycle as its clear command. A long run then drives random command words, enables and events together, so that these collisions occur many times across all flags. Every cycle is compared against a behavioural model in the bench.

// File: rtl/ssc_stat_pkg.sv
package ssc_stat_pkg;
   localparam int NFLAG  = 8;  // 6 errors, host select, enable
   localparam int NEVT   = 6;  // event inputs
   localparam int NGATED = 5;  // events that have an enable
   localparam int BUSY_POS = 13;

   // internal flag index: 0 txov, 1 rxov, 2 abort, 3 txun, 4 rxun,
   // 5 mode fault, 6 host select, 7 enable
   function automatic int set_pos(input int i);
      case (i)
         0: return 12;
         1: return 13;
         2: return 14;
         3: return 15;
         4: return 5;
         5: return 7;
         6: return 3;
         default: return 1;
      endcase
   endfunction

   function automatic int clr_pos(input int i);
      case (i)
         0: return 8;
         1: return 9;
         2: return 10;
         3: return 11;
         4: return 4;
         5: return 6;
         6: return 2;
         default: return 0;
      endcase
   endfunction

   function automatic int stat_pos(input int i);
      case (i)
         0: return 8;
         1: return 9;
         2: return 10;
         3: return 11;
         4: return 12;
         5: return 7;
         6: return 1;
         default: return 0;
      endcase
   endfunction
endpackage

// File: rtl/ssc_cmd_decode.sv
module ssc_cmd_decode
   import ssc_stat_pkg::*;
#(
   parameter int CMD_W = 16
) (
   input  logic             we_i,
   input  logic [CMD_W-1:0] word_i,
   output logic [NFLAG-1:0] set_o,
   output logic [NFLAG-1:0] clr_o
);
   if (CMD_W < 16) begin : g_bad_width
      $error("ssc_cmd_decode: CMD_W must be at least 16");
   end

   for (genvar i = 0; i < NFLAG; i++) begin : g_dec
      assign set_o[i] = we_i & word_i[set_pos(i)];
      assign clr_o[i] = we_i & word_i[clr_pos(i)];
   end
endmodule

// File: rtl/ssc_flag_cell.sv
module ssc_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic evt_i,
   output logic q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)                q_o <= 1'b0;
      else if (evt_i)            q_o <= 1'b1;
      else if (set_i && !clr_i)  q_o <= 1'b1;
      else if (clr_i && !set_i)  q_o <= 1'b0;
   end

   p_sw_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && !clr_i) |=> q_o);
   p_sw_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i && !evt_i) |=> !q_o);
   p_both_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && clr_i && !evt_i) |=> $stable(q_o));
   p_evt_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> q_o);
endmodule

// File: rtl/ssc_status_ctl.sv
module ssc_status_ctl
   import ssc_stat_pkg::*;
#(
   parameter int CMD_W   = 16,
   parameter int STAT_W  = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic [CMD_W-1:0]  cmd_word,
   input  logic [NGATED-1:0] err_en,
   input  logic [NEVT-1:0]   err_evt,
   input  logic              busy_i,
   output logic [STAT_W-1:0] status,
   output logic              err_irq
);
   localparam int NERR = NEVT;

   if (STAT_W <= BUSY_POS) begin : g_bad_stat
      $error("ssc_status_ctl: STAT_W must exceed the busy position");
   end

   logic [NFLAG-1:0] set_v, clr_v, evt_v, flag_q;

   ssc_cmd_decode #(.CMD_W(CMD_W)) u_dec (
      .we_i(cmd_we), .word_i(cmd_word), .set_o(set_v), .clr_o(clr_v)
   );

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      if (i < NGATED) begin : g_gated
         assign evt_v[i] = err_evt[i] & err_en[i];
      end else if (i < NEVT) begin : g_ungated
         assign evt_v[i] = err_evt[i];
      end else begin : g_noevt
         assign evt_v[i] = 1'b0;
      end
      ssc_flag_cell u_cell (
         .clk(clk), .rst_n(rst_n), .set_i(set_v[i]), .clr_i(clr_v[i]),
         .evt_i(evt_v[i]), .q_o(flag_q[i])
      );
   end

   always_comb begin
      status = '0;
      for (int i = 0; i < NFLAG; i++) status[stat_pos(i)] = flag_q[i];
      status[BUSY_POS] = busy_i;
   end

   logic any_err;
   assign any_err = |flag_q[NERR-1:0];

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= any_err;
      end
      assign err_irq = irq_q;
   end else begin : g_irq_comb
      assign err_irq = any_err;
      p_irq_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
         err_irq == (|status[12:7]));
   end

   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_we && err_evt == '0) |=> $stable(flag_q));
   p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_we && err_en == '0 && !err_evt[NEVT-1]) |=> $stable(flag_q));
   p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      status[BUSY_POS] == busy_i);
endmodule

// File: tb/ssc_status_ctl_tb.sv
module ssc_status_ctl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_we = 1'b0;
   logic [15:0] cmd_word = '0;
   logic [4:0]  err_en = '0;
   logic [5:0]  err_evt = '0;
   logic        busy_i = 1'b0;
   logic [15:0] status;
   logic        err_irq;

   int n_chk = 0, n_fail = 0;
   bit model [8];
   bit done = 1'b0;

   always #10 clk = ~clk;

   ssc_status_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_word(cmd_word),
      .err_en(err_en), .err_evt(err_evt), .busy_i(busy_i),
      .status(status), .err_irq(err_irq)
   );

   // behavioural reference: bit positions taken from the requirements
   int setp [8] = '{12, 13, 14, 15, 5, 7, 3, 1};
   int clrp [8] = '{8, 9, 10, 11, 4, 6, 2, 0};
   int stp  [8] = '{8, 9, 10, 11, 12, 7, 1, 0};

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) model[i] = 1'b0;
      end else begin
         for (int i = 0; i < 8; i++) begin
            bit ev, s, c;
            ev = (i < 5) ? (err_evt[i] && err_en[i]) : (i == 5 ? err_evt[5] : 1'b0);
            s = cmd_we && cmd_word[setp[i]];
            c = cmd_we && cmd_word[clrp[i]];
            if (ev) model[i] = 1'b1;
            else if (s && !c) model[i] = 1'b1;
            else if (c && !s) model[i] = 1'b0;
         end
      end
   end

   function automatic logic [15:0] model_stat();
      logic [15:0] v = '0;
      for (int i = 0; i < 8; i++) v[stp[i]] = model[i];
      v[13] = busy_i;
      return v;
   endfunction

   function automatic logic model_irq();
      logic r = 1'b0;
      for (int i = 0; i < 6; i++) r |= model[i];
      return r;
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model (R8 layout, R9 interrupt)
   always begin
      @(posedge clk);
      #5;
      if (rst_n && !done) begin
         chk("R8 model status", status, model_stat());
         chk("R9 model irq", {15'd0, err_irq}, {15'd0, model_irq()});
      end
   end

   task automatic step(input logic we, input logic [15:0] w, input logic [4:0] en,
                       input logic [5:0] ev, input logic bz);
      @(negedge clk);
      cmd_we = we; cmd_word = w; err_en = en; err_evt = ev; busy_i = bz;
      @(posedge clk);
      #5;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      #5;
      chk("R1 reset status", status, 16'h0000);
      chk("R1 reset irq", {15'd0, err_irq}, 16'h0000);
      @(negedge clk); rst_n = 1'b1;

      step(1, 16'h000A, 0, 0, 0);  chk("R2 set host+enable", status, 16'h0003);
      step(1, 16'hF0A0, 0, 0, 0);  chk("R2 set all errors", status, 16'h1F83);
      chk("R9 irq raised", {15'd0, err_irq}, 16'h0001);
      step(1, 16'h0F50, 0, 0, 0);  chk("R9 clear-all write", status, 16'h0003);
      chk("R9 irq dropped", {15'd0, err_irq}, 16'h0000);
      step(1, 16'h000C, 0, 0, 0);  chk("R4 set+clear host", status, 16'h0003);
      step(1, 16'h0005, 0, 0, 0);  chk("R3 clear host+enable", status, 16'h0000);
      step(0, 16'h0000, 5'h00, 6'h1F, 0); chk("R6 gated events ignored", status, 16'h0000);
      step(0, 16'h0000, 5'h00, 6'h20, 0); chk("R5 mode fault ungated", status, 16'h0080);
      step(1, 16'h0040, 0, 0, 0);  chk("R3 clear mode fault", status, 16'h0000);
      step(0, 16'h0000, 5'h1F, 6'h1F, 0); chk("R5 enabled events", status, 16'h1F00);
      step(1, 16'h0F50, 0, 0, 0);  chk("R3 clear errors", status, 16'h0000);
      step(1, 16'h0100, 5'h01, 6'h01, 0); chk("R7 event beats clear", status, 16'h0100);
      step(0, 16'hFFFF, 0, 0, 0);  chk("R10 no strobe", status, 16'h0100);
      step(0, 16'h0000, 0, 0, 1);  chk("R8 busy mirrored", status, 16'h2100);

      for (int k = 0; k < 400; k++) begin
         step($urandom_range(0, 1), 16'($urandom), 5'($urandom), 6'($urandom & $urandom),
              1'($urandom));
      end
      done = 1'b1;
      summary();
   end
endmodule